// File: doc/BRIEF.md
# Basic Interval Timer with Watchdog and Stop-Release Delay

The block divides the system clock through a free-running prescaler, picks one of eight divided rates by software, and advances an 8-bit interval counter at that rate. Every time that counter wraps to zero it emits a one-cycle tick. An 11-bit watchdog counter advances at the same selected rate while the processor runs. If software does not clear it in time, it wraps and emits a one-cycle system reset request.

The same counter also times the oscillator settling delay after stop mode. While `stop_i` is high the counters freeze and the processor clock enable is low. A wake event, which may come from reset or from an interrupt, restarts the prescaler and the interval counter. The enable then stays low for `STAB_BASE` times 32 selected-source ticks, or `STAB_BASE` times 16 when the short wait is selected. The block counts that delay as wraps of the 8-bit counter.

Top module: `basic_timer_wdt`

## Requirements
- R1: After reset `cnt_o`=0, `tick_o`=0, `wdt_rst_o`=0 and `cpu_en_o`=1. The source select is 7 (slowest), the watchdog is enabled and the wait multiplier is 32. With no write, `cnt_o` reads 2 after 256 clock edges.
- R2: `wr_data_i[2:0]`=k selects a source tick on every edge where the low k bits of a free-running 7-bit prescaler are all ones. That is one tick per 2^k clocks, and k=0 gives a tick on every edge. The interval counter advances by one per source tick.
- R3: When the interval counter wraps from 0xFF to 0x00, `tick_o` is high for exactly the cycle in which `cnt_o` shows 0x00.
- R4: In run state with the watchdog enabled, the 11-bit watchdog counter advances once per source tick. On the edge where it wraps from 2047, `wdt_rst_o` pulses high for one cycle.
- R5: A write with `wr_data_i[4]`=1 zeroes the watchdog counter at that edge. This takes priority over an increment or wrap in the same cycle, so no reset pulse follows that edge.
- R6: While the stored bit `wr_data_i[5]` is 1, the watchdog counter is held at zero and `wdt_rst_o` never pulses. After re-enabling, the next pulse comes 2048 ticks later.
- R7: `stop_i` high in run state drops `cpu_en_o` at the next edge. From then on the prescaler, the interval counter and the watchdog hold their values.
- R8: `wake_i` while stopped clears the prescaler and the interval counter. `cpu_en_o` then stays low until the edge that completes `STAB_BASE`×32 source ticks, and rises at that edge.
- R9: With the stored bit `wr_data_i[3]`=1, the wait of R8 is `STAB_BASE`×16 source ticks.
- R10: `wake_i` outside stop state has no effect: the count continues and `cpu_en_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | SEL_W+3 | [2:0] source select, [3] short wait, [4] watchdog clear (not stored), [5] watchdog off |
| stop_i | input | 1 | Stop mode request |
| wake_i | input | 1 | Stop release event (reset or interrupt) |
| cnt_o | output | CNT_W | Interval counter value |
| tick_o | output | 1 | One-cycle pulse on counter wrap |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| cpu_en_o | output | 1 | Processor clock enable |

## Verification
A wrong prescaler tap or a wrong select decode shows up within one divided period. `cnt_o` then drifts from the expected quotient, so the value read after 255 clocks exposes it for every select. A watchdog counter that is off by one, or a clear that loses priority, moves the reset pulse by exactly one edge or adds a pulse. Probes one cycle either side of the expected edge catch this within 2048 ticks. A wrong wait length or a wrong multiplier decode shifts the rise of `cpu_en_o` by a whole wrap of 256 ticks, so probes just before and just at the computed edge separate them.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_STOP, ST_STAB} bt_state_e;

  // control word bit positions above the source select field
  localparam int HALF_OFS = 0;
  localparam int CLR_OFS  = 1;
  localparam int OFF_OFS  = 2;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (run_i)   pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    for (int k = 0; k < PRE_W; k++) mask[k] = (k < int'(sel_i));
  end

  assign tick_o = run_i && !clear_i && ((pre_q & mask) == mask);
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 8,
  parameter int WDT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             cnt_clr_i,
  input  logic             wdt_run_i,
  input  logic             wdt_clr_i,
  input  logic             wdt_off_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             tick_o,
  output logic             wdt_ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [WDT_W-1:0] wdt_q;
  logic             tick_q, ovf_q;

  assign wrap_o = adv_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (adv_i) cnt_q <= cnt_q + 1'b1;
      tick_q <= wrap_o;
    end
  end

  // clear wins over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wdt_clr_i || wdt_off_i) begin
      wdt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wdt_run_i && adv_i) begin
      wdt_q <= wdt_q + 1'b1;
      ovf_q <= &wdt_q;
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign tick_o    = tick_q;
  assign wdt_ovf_o = ovf_q;
endmodule

// File: rtl/bt_stab_ctrl.sv
module bt_stab_ctrl
  import bt_pkg::*;
#(
  parameter int WRAPS = 256
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stop_i,
  input  logic      wake_i,
  input  logic      half_i,
  input  logic      wrap_i,
  output bt_state_e state_o,
  output logic      restart_o,
  output logic      cpu_en_o
);
  localparam int WRAP_W = (WRAPS > 2) ? $clog2(WRAPS) : 1;
  localparam logic [WRAP_W-1:0] LAST_FULL = WRAP_W'(WRAPS - 1);
  localparam logic [WRAP_W-1:0] LAST_HALF = WRAP_W'(WRAPS / 2 - 1);

  bt_state_e         state_q, state_d;
  logic [WRAP_W-1:0] wraps_q;
  logic [WRAP_W-1:0] last;
  logic              en_q;

  assign last      = half_i ? LAST_HALF : LAST_FULL;
  assign restart_o = (state_q == ST_STOP) && wake_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_i) state_d = ST_STOP;
      ST_STOP: if (wake_i) state_d = ST_STAB;
      ST_STAB: if (wrap_i && wraps_q == last) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wraps_q <= '0;
      en_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      en_q    <= (state_d == ST_RUN);
      if (restart_o) wraps_q <= '0;
      else if (state_q == ST_STAB && wrap_i) wraps_q <= wraps_q + 1'b1;
    end
  end

  assign state_o  = state_q;
  assign cpu_en_o = en_q;
endmodule

// File: rtl/basic_timer_wdt.sv
module basic_timer_wdt
  import bt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int WDT_W     = 11,
  parameter int SEL_W     = 3,
  parameter int STAB_BASE = 2048
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W+2:0] wr_data_i,
  input  logic             stop_i,
  input  logic             wake_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             wdt_rst_o,
  output logic             cpu_en_o
);
  localparam int WRAPS = STAB_BASE * 32 / (1 << CNT_W);

  logic [SEL_W-1:0] sel_q;
  logic             half_q, off_q;
  logic             wdt_clr, src_tick, restart, wrap;
  bt_state_e        state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '1;
      half_q <= 1'b0;
      off_q  <= 1'b0;
    end else if (wr_en_i) begin
      sel_q  <= wr_data_i[SEL_W-1:0];
      half_q <= wr_data_i[SEL_W+HALF_OFS];
      off_q  <= wr_data_i[SEL_W+OFF_OFS];
    end
  end

  assign wdt_clr = wr_en_i && wr_data_i[SEL_W+CLR_OFS];

  bt_prescaler #(.SEL_W(SEL_W)) i_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q != ST_STOP),
    .clear_i (restart),
    .sel_i   (sel_q),
    .tick_o  (src_tick)
  );

  bt_counter #(.CNT_W(CNT_W), .WDT_W(WDT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (src_tick),
    .cnt_clr_i (restart),
    .wdt_run_i (state_q == ST_RUN),
    .wdt_clr_i (wdt_clr),
    .wdt_off_i (off_q),
    .cnt_o     (cnt_o),
    .wrap_o    (wrap),
    .tick_o    (tick_o),
    .wdt_ovf_o (wdt_rst_o)
  );

  bt_stab_ctrl #(.WRAPS(WRAPS)) i_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_i    (stop_i),
    .wake_i    (wake_i),
    .half_i    (half_q),
    .wrap_i    (wrap),
    .state_o   (state_q),
    .restart_o (restart),
    .cpu_en_o  (cpu_en_o)
  );
endmodule

// File: rtl/bt_chk.sv
module bt_chk
  import bt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [SEL_W+2:0] wr_data_i,
  input logic             stop_i,
  input logic             wake_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tick_o,
  input logic             wdt_rst_o,
  input logic             cpu_en_o,
  input bt_state_e        state_q
);
  // R3
  tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (cnt_o == '0));

  // R4
  wdt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  // R5
  clr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[SEL_W+CLR_OFS]) |=> !wdt_rst_o);

  // R7
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !wake_i) |=> $stable(cnt_o));

  // R8
  stab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAB) |-> !cpu_en_o);

  // R10
  wake_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !stop_i) |=> cpu_en_o);
endmodule

bind basic_timer_wdt bt_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_bt_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .stop_i    (stop_i),
  .wake_i    (wake_i),
  .cnt_o     (cnt_o),
  .tick_o    (tick_o),
  .wdt_rst_o (wdt_rst_o),
  .cpu_en_o  (cpu_en_o),
  .state_q   (state_q)
);

// File: tb/test_basic_timer_wdt.sv
module test_basic_timer_wdt;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int STAB_BASE = 256;
  localparam int WAIT_FULL = STAB_BASE * 32;
  localparam int WAIT_HALF = STAB_BASE * 16;

  // {select, expected count after 255 edges}
  localparam logic [10:0] VEC [0:7] = '{
    {3'd0, 8'd255}, {3'd1, 8'd128}, {3'd2, 8'd64}, {3'd3, 8'd32},
    {3'd4, 8'd16},  {3'd5, 8'd8},   {3'd6, 8'd4},  {3'd7, 8'd2}};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [SEL_W+2:0] wr_data_i = '0;
  logic             stop_i = 1'b0;
  logic             wake_i = 1'b0;
  logic [CNT_W-1:0] cnt_o;
  logic             tick_o, wdt_rst_o, cpu_en_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  basic_timer_wdt #(.STAB_BASE(STAB_BASE)) i_basic_timer_wdt (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .stop_i, .wake_i,
    .cnt_o, .tick_o, .wdt_rst_o, .cpu_en_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; stop_i = 1'b0; wake_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // write lands on the next edge; returns right after it
  task automatic wr(input logic [SEL_W+2:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic stab_run(input logic [SEL_W+2:0] d, input int wait_len, input string req);
    logic [CNT_W-1:0] held;
    do_reset();
    wr(d);
    repeat (10) @(negedge clk_i);
    stop_i = 1'b1;
    @(negedge clk_i);
    chk(cpu_en_o == 1'b0, "R7", cpu_en_o, 0);
    held = cnt_o;
    repeat (40) @(negedge clk_i);
    chk(cnt_o == held, "R7", cnt_o, held);
    stop_i = 1'b0; wake_i = 1'b1;
    @(negedge clk_i);
    wake_i = 1'b0;
    chk(cnt_o == 0, req, cnt_o, 0);
    repeat (wait_len - 1) @(negedge clk_i);
    chk(cpu_en_o == 1'b0, req, cpu_en_o, 0);
    @(negedge clk_i);
    chk(cpu_en_o == 1'b1, req, cpu_en_o, 1);
  endtask

  initial begin
    int pulses;
    // R1 reset state and defaults
    do_reset();
    chk(cnt_o == 0 && !tick_o && !wdt_rst_o, "R1", cnt_o, 0);
    chk(cpu_en_o == 1'b1, "R1", cpu_en_o, 1);
    repeat (256) @(negedge clk_i);
    chk(cnt_o == 2, "R1", cnt_o, 2);

    // R2 select table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr({3'b000, VEC[i][10:8]});
      repeat (255) @(negedge clk_i);
      chk(cnt_o == VEC[i][7:0], "R2", cnt_o, VEC[i][7:0]);
    end

    // R3 wrap tick
    do_reset();
    wr(6'h00);
    repeat (255) @(negedge clk_i);
    chk(cnt_o == 255 && !tick_o, "R3", tick_o, 0);
    @(negedge clk_i);
    chk(cnt_o == 0 && tick_o, "R3", tick_o, 1);
    @(negedge clk_i);
    chk(cnt_o == 1 && !tick_o, "R3", tick_o, 0);

    // R4 watchdog overflow
    do_reset();
    wr(6'h00);
    repeat (2047) @(negedge clk_i);
    chk(!wdt_rst_o, "R4", wdt_rst_o, 0);
    @(negedge clk_i);
    chk(wdt_rst_o, "R4", wdt_rst_o, 1);
    @(negedge clk_i);
    chk(!wdt_rst_o, "R4", wdt_rst_o, 0);

    // R5 clear on the overflow edge
    do_reset();
    wr(6'h00);
    repeat (2047) @(negedge clk_i);
    wr(6'h10);
    chk(!wdt_rst_o, "R5", wdt_rst_o, 0);
    repeat (2047) @(negedge clk_i);
    chk(!wdt_rst_o, "R5", wdt_rst_o, 0);
    @(negedge clk_i);
    chk(wdt_rst_o, "R5", wdt_rst_o, 1);

    // R6 watchdog off, then back on
    do_reset();
    wr(6'h20);
    pulses = 0;
    repeat (3000) begin @(negedge clk_i); pulses += int'(wdt_rst_o); end
    chk(pulses == 0, "R6", pulses, 0);
    wr(6'h00);
    pulses = 0;
    repeat (2047) begin @(negedge clk_i); pulses += int'(wdt_rst_o); end
    chk(pulses == 0, "R6", pulses, 0);
    @(negedge clk_i);
    chk(wdt_rst_o, "R6", wdt_rst_o, 1);

    // R8 default x32 wait, R9 x16 wait
    stab_run(6'h00, WAIT_FULL, "R8");
    stab_run(6'h08, WAIT_HALF, "R9");

    // R10 wake outside stop
    do_reset();
    wr(6'h00);
    repeat (100) @(negedge clk_i);
    wake_i = 1'b1;
    @(negedge clk_i);
    wake_i = 1'b0;
    chk(cnt_o == 101, "R10", cnt_o, 101);
    chk(cpu_en_o == 1'b1, "R10", cpu_en_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule